// File: doc/BRIEF.md
# Interrupt Descriptor Ring Writer

This block moves interrupt descriptors from an on-chip staging queue into a circular buffer in host memory. Software chooses the buffer by writing a base address register and a length register, with the length given in quadwords. Each descriptor is one dword. The block writes descriptors one after another through a simple memory write port. When a run of descriptors ends, it writes a status word to a fixed host address. The status word carries the write pointer and a full flag. The block then raises a level interrupt.

Software reports how far it has read by writing a read pointer register. The ring is treated as full when one more advance of the write pointer would make it equal to the read pointer. When the ring is full, the block stops taking descriptors, sets the full flag in the status word, and waits. A later write to the read pointer clears the flag and lets the transfers resume. A write to either the base or the length register resets all ring state at once. Software can therefore move the ring to a new buffer while the block is running.

Top module: `intq_ring_writer`

## Requirements
- R1: After reset the interrupt is low and no memory request is made. The ring state is zero: the write pointer is 0, the full flag is clear and no status is pending. The first status word after the first descriptor therefore reads 0x00000001.
- R2: Each descriptor is written at base + 4 × write pointer, with the descriptor as data. It is removed from the staging queue (stg_ready high) in the cycle its write is accepted.
- R3: The write pointer counts dwords. It wraps to 0 when it reaches twice the quadword length.
- R4: A length write below 2 is taken as 2 quadwords. A length write above MAX_QW is taken as MAX_QW.
- R5: When the staging queue runs empty after one or more descriptor writes, one status word is written to STATUS_ADDR. The full flag is at bit 31, the write pointer is in bits 15:0, and every other bit is 0.
- R6: If advancing the write pointer would make it equal to the read pointer, no descriptor is written. The full flag is set and a status word with bit 31 high is written. After that, nothing more is written until the host writes the read pointer.
- R7: A write to the read pointer register clears the full flag, and descriptor writes resume.
- R8: The interrupt rises in the cycle after a status write is accepted. It stays high until the host writes the control register with bit 0 set.
- R9: A write to the base or length register does all of the following in the next cycle: it clears the write pointer, the read pointer, the full flag, the pending status and the interrupt, and it withdraws any outstanding memory request. The next descriptor goes to the new base.
- R10: A memory request that has not been accepted stays asserted with a stable address until the memory accepts it, unless a base or length write withdraws it.
- R11: Host register select values are: 0 for base, 1 for length in quadwords, 2 for read pointer in dwords, and 3 for control, where bit 0 acknowledges the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_en | input | 1 | Host register write strobe |
| hw_sel | input | 2 | Host register select |
| hw_data | input | 32 | Host register write data |
| stg_valid | input | 1 | Staging queue holds a descriptor |
| stg_data | input | DW | Descriptor at the head of the staging queue |
| stg_ready | output | 1 | Head descriptor consumed this cycle |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write byte address |
| mem_data | output | DW | Memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| irq | output | 1 | Level interrupt to the host |

## Verification
The embedded assertions check the following on every cycle:
- a stalled request holds its address;
- no descriptor write happens while the full flag is set;
- the interrupt rises after each accepted status write and stays up until acknowledged;
- a configuration write empties the sequencer;
- the write pointer always stays inside the ring and wraps at its end.

Other behaviour can only be shown by the directed scenarios:
- the address and data of each descriptor;
- where a run of descriptors ends and the status word is written;
- the value of the status word in the full and not-full cases;
- the clamping of short and long lengths;
- the resume after a read-pointer write;
- the move to a new base in the middle of a request.

// File: rtl/intq_ring_pkg.sv
`timescale 1ns/1ps
package intq_ring_pkg;

   // Host register select codes (R11)
   typedef enum logic [1:0] {
      SEL_BASE = 2'd0,
      SEL_LEN  = 2'd1,
      SEL_RPTR = 2'd2,
      SEL_CTRL = 2'd3
   } host_sel_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_DESC = 2'd1,
      SQ_STAT = 2'd2
   } seq_state_e;

   localparam int unsigned STAT_FULL_BIT = 31;
   localparam int unsigned STAT_PTR_BITS = 16;

endpackage

// File: rtl/intq_ring_cfg.sv
`timescale 1ns/1ps
module intq_ring_cfg
   import intq_ring_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned MAX_QW = 32768,
   parameter int unsigned PTR_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_en,
   input  logic [1:0]       hw_sel,
   input  logic [31:0]      hw_data,
   output logic [AW-1:0]    base_q,
   output logic [PTR_W:0]   span_dw,
   output logic [PTR_W-1:0] rptr_q,
   output logic             ring_rst,
   output logic             rptr_wr,
   output logic             irq_ack
);

   localparam logic [31:0] MIN_QW_C = 32'd2;
   localparam logic [31:0] MAX_QW_C = 32'(MAX_QW);

   host_sel_e   sel;
   logic [31:0] qw_c;

   assign sel      = host_sel_e'(hw_sel);
   assign ring_rst = hw_en && ((sel == SEL_BASE) || (sel == SEL_LEN));
   assign rptr_wr  = hw_en && (sel == SEL_RPTR);
   assign irq_ack  = hw_en && (sel == SEL_CTRL) && hw_data[0];

   // Length clamp into [2, MAX_QW] quadwords (R4)
   always_comb begin
      if (hw_data < MIN_QW_C)      qw_c = MIN_QW_C;
      else if (hw_data > MAX_QW_C) qw_c = MAX_QW_C;
      else                         qw_c = hw_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         span_dw <= (PTR_W+1)'(4);
         rptr_q  <= '0;
      end else if (hw_en) begin
         case (sel)
            SEL_BASE: begin
               base_q <= AW'(hw_data);
               rptr_q <= '0;
            end
            SEL_LEN: begin
               span_dw <= (PTR_W+1)'(qw_c << 1);
               rptr_q  <= '0;
            end
            SEL_RPTR: rptr_q <= hw_data[PTR_W-1:0];
            default:  ;
         endcase
      end
   end

   AST_SPAN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (span_dw >= (PTR_W+1)'(4)) && (span_dw <= (PTR_W+1)'(2*MAX_QW))) else $error("span"); // R4

endmodule

// File: rtl/intq_ring_ptr.sv
`timescale 1ns/1ps
module intq_ring_ptr #(
   parameter int unsigned PTR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [PTR_W:0]   span_dw,
   input  logic [PTR_W-1:0] rptr,
   output logic [PTR_W-1:0] wptr,
   output logic             at_limit
);

   logic [PTR_W:0]   inc;
   logic [PTR_W-1:0] wnext;

   assign inc      = {1'b0, wptr} + (PTR_W+1)'(1);
   assign wnext    = (inc >= span_dw) ? '0 : inc[PTR_W-1:0];
   assign at_limit = (wnext == rptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   wptr <= '0;
      else if (clr) wptr <= '0;
      else if (adv) wptr <= wnext;
   end

   AST_WPTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, wptr} < span_dw)) else $error("wptr outside ring"); // R3
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && (inc == span_dw)) |=> (wptr == '0)) else $error("no wrap"); // R3

endmodule

// File: rtl/intq_ring_seq.sv
`timescale 1ns/1ps
module intq_ring_seq
   import intq_ring_pkg::*;
#(
   parameter int unsigned   AW          = 32,
   parameter int unsigned   DW          = 32,
   parameter int unsigned   PTR_W       = 16,
   parameter logic [AW-1:0] STATUS_ADDR = AW'(64)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ring_rst,
   input  logic             rptr_wr,
   input  logic             irq_ack,
   input  logic             stg_valid,
   input  logic [DW-1:0]    stg_data,
   output logic             stg_ready,
   output logic             mem_req,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_data,
   input  logic             mem_ack,
   input  logic [AW-1:0]    base_q,
   input  logic [PTR_W-1:0] wptr,
   input  logic             at_limit,
   output logic             adv,
   output logic             irq
);

   seq_state_e    st;
   logic          full_q;
   logic          pend_q;
   logic [DW-1:0] stat_word;

   assign mem_req   = (st != SQ_IDLE);
   assign stg_ready = (st == SQ_DESC) && mem_ack && !ring_rst;
   assign adv       = stg_ready;

   // Status word layout: full at bit 31, pointer in the low bits (R5)
   always_comb begin
      stat_word                = '0;
      stat_word[STAT_FULL_BIT] = full_q;
      stat_word[PTR_W-1:0]     = wptr;
   end

   always_comb begin
      if (st == SQ_STAT) begin
         mem_addr = STATUS_ADDR;
         mem_data = stat_word;
      end else begin
         mem_addr = base_q + AW'({wptr, 2'b00});
         mem_data = stg_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         full_q <= 1'b0;
         pend_q <= 1'b0;
         irq    <= 1'b0;
      end else if (ring_rst) begin
         st     <= SQ_IDLE;
         full_q <= 1'b0;
         pend_q <= 1'b0;
         irq    <= 1'b0;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (stg_valid && !full_q && !at_limit) begin
                  st <= SQ_DESC;
               end else if (stg_valid && !full_q && at_limit) begin
                  full_q <= 1'b1;
                  st     <= SQ_STAT;
               end else if (pend_q) begin
                  st <= SQ_STAT;
               end
            end
            SQ_DESC: if (mem_ack) begin
               pend_q <= 1'b1;
               st     <= SQ_IDLE;
            end
            SQ_STAT: if (mem_ack) begin
               pend_q <= 1'b0;
               st     <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
         if (rptr_wr) full_q <= 1'b0;
         if ((st == SQ_STAT) && mem_ack) irq <= 1'b1;
         else if (irq_ack)               irq <= 1'b0;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !ring_rst) |=> (mem_req && $stable(mem_addr))) else $error("req dropped"); // R10
   AST_NO_DESC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_DESC) |-> !full_q) else $error("desc while full"); // R6
   AST_IRQ_ON_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SQ_STAT) && mem_ack && !ring_rst) |=> irq) else $error("irq missing"); // R8
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack && !ring_rst) |=> irq) else $error("irq dropped"); // R8
   AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ring_rst |=> (!irq && !mem_req && (wptr == '0))) else $error("cfg reset"); // R9

endmodule

// File: rtl/intq_ring_writer.sv
`timescale 1ns/1ps
module intq_ring_writer #(
   parameter int unsigned   AW          = 32,
   parameter int unsigned   DW          = 32,
   parameter int unsigned   MAX_QW      = 32768,
   parameter logic [AW-1:0] STATUS_ADDR = AW'(64)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hw_en,
   input  logic [1:0]    hw_sel,
   input  logic [31:0]   hw_data,
   input  logic          stg_valid,
   input  logic [DW-1:0] stg_data,
   output logic          stg_ready,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_data,
   input  logic          mem_ack,
   output logic          irq
);

   localparam int unsigned PTR_W = $clog2(2*MAX_QW);

   generate
      if (MAX_QW < 2) begin : g_bad_min
         $error("MAX_QW must be at least 2");
      end
      if ((MAX_QW & (MAX_QW - 1)) != 0) begin : g_bad_pow2
         $error("MAX_QW must be a power of two");
      end
      if (2*MAX_QW > 65536) begin : g_bad_max
         $error("ring exceeds 64K dwords");
      end
      if (DW < 32) begin : g_bad_dw
         $error("DW must hold the status word");
      end
      if (AW < PTR_W + 2) begin : g_bad_aw
         $error("AW too narrow for the ring");
      end
   endgenerate

   logic [AW-1:0]    base_q;
   logic [PTR_W:0]   span_dw;
   logic [PTR_W-1:0] rptr_q;
   logic [PTR_W-1:0] wptr;
   logic             ring_rst;
   logic             rptr_wr;
   logic             irq_ack;
   logic             at_limit;
   logic             adv;

   intq_ring_cfg #(.AW(AW), .MAX_QW(MAX_QW), .PTR_W(PTR_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_en    (hw_en),
      .hw_sel   (hw_sel),
      .hw_data  (hw_data),
      .base_q   (base_q),
      .span_dw  (span_dw),
      .rptr_q   (rptr_q),
      .ring_rst (ring_rst),
      .rptr_wr  (rptr_wr),
      .irq_ack  (irq_ack)
   );

   intq_ring_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ring_rst),
      .adv      (adv),
      .span_dw  (span_dw),
      .rptr     (rptr_q),
      .wptr     (wptr),
      .at_limit (at_limit)
   );

   intq_ring_seq #(.AW(AW), .DW(DW), .PTR_W(PTR_W), .STATUS_ADDR(STATUS_ADDR)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ring_rst  (ring_rst),
      .rptr_wr   (rptr_wr),
      .irq_ack   (irq_ack),
      .stg_valid (stg_valid),
      .stg_data  (stg_data),
      .stg_ready (stg_ready),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .mem_ack   (mem_ack),
      .base_q    (base_q),
      .wptr      (wptr),
      .at_limit  (at_limit),
      .adv       (adv),
      .irq       (irq)
   );

endmodule

// File: tb/intq_ring_writer_bench.sv
`timescale 1ns/1ps
module intq_ring_writer_bench;

   localparam logic [31:0] STAT = 32'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_en = 1'b0;
   logic [1:0]  hw_sel = 2'd0;
   logic [31:0] hw_data = '0;
   logic        stg_valid;
   logic [31:0] stg_data;
   logic        stg_ready;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_data;
   logic        mem_ack = 1'b0;
   logic        irq;

   logic [31:0] stg_q [0:255];
   logic [7:0]  rd = '0;
   logic [7:0]  wr = '0;
   logic [31:0] log_a [0:63];
   logic [31:0] log_d [0:63];
   int          log_n = 0;
   int          stall = 0;
   int          n_chk = 0;
   int          n_fail = 0;

   assign stg_valid = (rd != wr);
   assign stg_data  = stg_q[rd];

   always #10 clk = ~clk;

   intq_ring_writer #(.MAX_QW(8), .STATUS_ADDR(STAT)) u_intq_ring_writer (
      .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
      .stg_valid(stg_valid), .stg_data(stg_data), .stg_ready(stg_ready),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
      .irq(irq)
   );

   // Memory responder and staging pop model
   initial begin
      logic hs, is_desc;
      forever begin
         @(negedge clk);
         hs      = mem_req && mem_ack && !(hw_en && (hw_sel < 2'd2));
         is_desc = (mem_addr != STAT);
         if (hs && log_n < 64) begin
            log_a[log_n] = mem_addr;
            log_d[log_n] = mem_data;
            log_n++;
         end
         @(posedge clk);
         #1;
         if (hs && is_desc) rd = rd + 8'd1;
         if (mem_req) begin
            if (stall > 0) begin
               stall--;
               mem_ack = 1'b0;
            end else mem_ack = 1'b1;
         end else mem_ack = 1'b0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host_wr(input logic [1:0] sel, input logic [31:0] d);
      @(posedge clk); #2;
      hw_en = 1'b1; hw_sel = sel; hw_data = d;
      @(posedge clk); #2;
      hw_en = 1'b0;
   endtask

   task automatic push_n(input int n, input logic [31:0] seed);
      @(posedge clk); #2;
      for (int i = 0; i < n; i++) begin
         stg_q[wr] = seed + 32'(i);
         wr = wr + 8'd1;
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 irq after reset", {31'b0, irq}, 32'd0);
      chk("R1 no request after reset", {31'b0, mem_req}, 32'd0);
      chk("R1 no pop after reset", {31'b0, stg_ready}, 32'd0);
   endtask

   task automatic t_basic;
      host_wr(2'd0, 32'h1000);   // R11 select 0 = base
      host_wr(2'd1, 32'd4);      // R11 select 1 = length
      log_n = 0;
      push_n(3, 32'hA000_0000);
      settle(20);
      chk("R5 write count", 32'(log_n), 32'd4);
      for (int i = 0; i < 3; i++) begin
         chk("R2 desc addr", log_a[i], 32'h1000 + 32'(4*i));
         chk("R2 desc data", log_d[i], 32'hA000_0000 + 32'(i));
      end
      chk("R5 status addr", log_a[3], STAT);
      chk("R1 R5 status word", log_d[3], 32'h0000_0003);
      chk("R2 staging drained", {31'b0, stg_valid}, 32'd0);
      chk("R8 irq raised", {31'b0, irq}, 32'd1);
      settle(5);
      chk("R8 irq held", {31'b0, irq}, 32'd1);
      host_wr(2'd3, 32'd1);      // R11 select 3 bit 0 = acknowledge
      @(negedge clk);
      chk("R8 irq acknowledged", {31'b0, irq}, 32'd0);
   endtask

   task automatic t_wrap_full;
      host_wr(2'd0, 32'h2000);
      host_wr(2'd1, 32'd2);
      log_n = 0;
      push_n(5, 32'hB000_0000);
      settle(20);
      chk("R6 writes before full", 32'(log_n), 32'd4);
      for (int i = 0; i < 3; i++)
         chk("R6 desc addr", log_a[i], 32'h2000 + 32'(4*i));
      chk("R6 full status", log_d[3], 32'h8000_0003);
      chk("R6 stalled while full", {31'b0, mem_req}, 32'd0);
      chk("R6 descriptors kept", {31'b0, stg_valid}, 32'd1);
      host_wr(2'd3, 32'd1);
      host_wr(2'd2, 32'd2);      // R11 select 2 = read pointer
      settle(20);
      chk("R7 writes after resume", 32'(log_n), 32'd7);
      chk("R7 resumed addr", log_a[4], 32'h200C);
      chk("R7 resumed data", log_d[4], 32'hB000_0003);
      chk("R3 wrapped addr", log_a[5], 32'h2000);
      chk("R3 wrapped data", log_d[5], 32'hB000_0004);
      chk("R7 full cleared in status", log_d[6], 32'h0000_0001);
      host_wr(2'd3, 32'd1);
   endtask

   task automatic t_clamp_small;
      host_wr(2'd0, 32'h5000);
      host_wr(2'd1, 32'd1);
      log_n = 0;
      push_n(3, 32'hC000_0000);
      settle(20);
      chk("R4 short length writes", 32'(log_n), 32'd4);
      chk("R4 third slot addr", log_a[2], 32'h5008);
      chk("R4 short length status", log_d[3], 32'h0000_0003);
   endtask

   task automatic t_clamp_big;
      host_wr(2'd1, 32'd100);
      host_wr(2'd0, 32'h6000);
      log_n = 0;
      push_n(16, 32'hD000_0000);
      settle(60);
      chk("R4 long length writes", 32'(log_n), 32'd16);
      chk("R4 last slot addr", log_a[14], 32'h6038);
      chk("R4 clamped full status", log_d[15], 32'h8000_000F);
      chk("R4 one descriptor left", {24'b0, wr - rd}, 32'd1);
   endtask

   task automatic t_cfg_reset;
      logic [31:0] held;
      int guard;
      stall = 8;
      host_wr(2'd2, 32'd1);
      log_n = 0;
      guard = 0;
      @(negedge clk);
      while (!mem_req && guard < 20) begin
         @(negedge clk);
         guard++;
      end
      held = mem_addr;
      chk("R10 stalled addr", held, 32'h603C);
      @(negedge clk);
      chk("R10 request held", {31'b0, mem_req}, 32'd1);
      chk("R10 addr stable", mem_addr, held);
      chk("R9 irq before cfg", {31'b0, irq}, 32'd1);
      host_wr(2'd0, 32'h7000);
      @(negedge clk);
      chk("R9 irq cleared", {31'b0, irq}, 32'd0);
      chk("R9 request withdrawn", {31'b0, mem_req}, 32'd0);
      settle(30);
      chk("R9 writes after cfg", 32'(log_n), 32'd2);
      chk("R9 new base addr", log_a[0], 32'h7000);
      chk("R9 kept descriptor", log_d[0], 32'hD000_000F);
      chk("R9 status after cfg", log_d[1], 32'h0000_0001);
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_basic();
      t_wrap_full();
      t_clamp_small();
      t_clamp_big();
      t_cfg_reset();
      report();
   end

endmodule